// File: doc/BRIEF.md
# Four-Lane SHA-256 Sigma Unit

This execution unit applies the SHA-256 rotate/shift/XOR functions to a 128-bit vector. The vector holds four 32-bit word lanes, and all four are processed in one operation. A single kind bit picks the function family. Kind 0 selects the message-schedule pair (small sigma). Kind 1 selects the compression pair (big Sigma). A four-bit lane selector then picks, for each lane on its own, which member of that pair the lane applies. One issued operation can therefore mix two functions across its lanes.

Each operation is gated by a vector-enable status bit. When the bit is set, the four results appear together on a registered output one clock after issue. When the bit is clear, no result is produced. Instead the unit pulses an unavailable flag in the same cycle slot. Register files, instruction decode and the rest of the hash round sit outside this block.

Top module: `sha2_sigma_vec`

## Requirements
- R1: Lane i (i = 0..3) takes its input word from bits [127-32i -: 32] of `in_vec`, so lane 0 is the most significant word. Its result goes to the same bit positions of `out_vec`. Lane i is steered by bit i of `in_sel`.
- R2: With `in_kind`=0 and the lane's selector bit 0, the lane result is ROTR7(x) ^ ROTR18(x) ^ SHR3(x).
- R3: With `in_kind`=0 and the lane's selector bit 1, the lane result is ROTR17(x) ^ ROTR19(x) ^ SHR10(x). SHR is a logical shift that fills with zeros.
- R4: With `in_kind`=1 and the lane's selector bit 0, the lane result is ROTR2(x) ^ ROTR13(x) ^ ROTR22(x).
- R5: With `in_kind`=1 and the lane's selector bit 1, the lane result is ROTR6(x) ^ ROTR11(x) ^ ROTR25(x).
- R6: Lanes choose their function independently. Any of the 16 selector values yields the mixed per-lane results in one operation.
- R7: An operation issued with `in_valid`=1 and `vec_en`=1 at a rising edge gives `out_valid`=1 with its result during the following cycle only. Back-to-back issues give back-to-back results.
- R8: An operation issued with `in_valid`=1 and `vec_en`=0 gives `out_unavail`=1 and `out_valid`=0 during the following cycle only. `out_valid` and `out_unavail` are never high together.
- R9: While `rst` is high at a rising edge, both `out_valid` and `out_unavail` are low in the following cycle, whatever the other inputs are.
- R10: A rising edge with `in_valid`=0 leaves both `out_valid` and `out_unavail` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for one operation |
| in_vec | input | 128 | Source vector, four 32-bit lanes, lane 0 in the top word |
| in_kind | input | 1 | Function family: 0 message-schedule, 1 compression |
| in_sel | input | 4 | Per-lane member select, bit i for lane i |
| vec_en | input | 1 | Vector facility enable status |
| out_valid | output | 1 | Result valid, one cycle after an enabled issue |
| out_vec | output | 128 | Result vector, same lane layout as the input |
| out_unavail | output | 1 | One-cycle pulse: operation refused because vector facility disabled |

## Verification
Mis-steered lane wiring or a wrong selector bit shows as a wrong word in one lane on the first result after issue. That lane's word then matches one of the other three functions, or the value of a neighbouring lane. A wrong rotation amount, or a rotate used where a zero-fill shift belongs, shows on the first enabled operation whose input has set bits near the word edges. For this reason the corner words include single top and bottom bits and all ones. A stuck or mistimed valid or unavailable flag is visible in the cycle right after the issue, or in the cycle after that when it fails to drop.

// File: rtl/sha2_sigma_pkg.sv
package sha2_sigma_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned AMT_W  = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    // {kind, selector} forms the function code
    typedef enum logic [1:0] {
        SIG_MSG0 = 2'b00,
        SIG_MSG1 = 2'b01,
        SIG_CMP0 = 2'b10,
        SIG_CMP1 = 2'b11
    } sig_fn_e;

    // Per-function term amounts; last term is a rotate or a zero-fill shift
    typedef struct packed {
        logic [AMT_W-1:0] r_a;
        logic [AMT_W-1:0] r_b;
        logic [AMT_W-1:0] t_c;
        logic             c_is_rot;
    } term_plan_t;

    localparam term_plan_t PLAN_MSG0 = '{r_a: 5'd7,  r_b: 5'd18, t_c: 5'd3,  c_is_rot: 1'b0};
    localparam term_plan_t PLAN_MSG1 = '{r_a: 5'd17, r_b: 5'd19, t_c: 5'd10, c_is_rot: 1'b0};
    localparam term_plan_t PLAN_CMP0 = '{r_a: 5'd2,  r_b: 5'd13, t_c: 5'd22, c_is_rot: 1'b1};
    localparam term_plan_t PLAN_CMP1 = '{r_a: 5'd6,  r_b: 5'd11, t_c: 5'd25, c_is_rot: 1'b1};

    function automatic word_t rotr(input word_t w, input logic [AMT_W-1:0] n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {w, w} >> n;
        return dbl[WORD_W-1:0];
    endfunction

    // Used with constant plans only, so every shift reduces to wiring
    function automatic word_t apply_plan(input word_t w, input term_plan_t p);
        word_t third;
        third = p.c_is_rot ? rotr(w, p.t_c) : (w >> p.t_c);
        return rotr(w, p.r_a) ^ rotr(w, p.r_b) ^ third;
    endfunction

endpackage

// File: rtl/sha2_sigma_lane.sv
module sha2_sigma_lane
    import sha2_sigma_pkg::*;
(
    input  sig_fn_e fn,
    input  word_t   din,
    output word_t   dout
);

    localparam int unsigned NFN = 4;

    word_t cand [NFN];

    // All four functions computed in parallel on fixed wiring
    assign cand[SIG_MSG0] = apply_plan(din, PLAN_MSG0);
    assign cand[SIG_MSG1] = apply_plan(din, PLAN_MSG1);
    assign cand[SIG_CMP0] = apply_plan(din, PLAN_CMP0);
    assign cand[SIG_CMP1] = apply_plan(din, PLAN_CMP1);

    always_comb begin
        dout = cand[fn];
    end

endmodule

// File: rtl/sha2_sigma_stage.sv
module sha2_sigma_stage #(
    parameter int unsigned VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             refuse,
    input  logic [VEC_W-1:0] din,
    output logic             q_valid,
    output logic             q_unavail,
    output logic [VEC_W-1:0] q_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid   <= 1'b0;
            q_unavail <= 1'b0;
        end else begin
            q_valid   <= take;
            q_unavail <= refuse;
        end
    end

    // Data register loads only on accepted work
    always_ff @(posedge clk) begin
        if (take) begin
            q_data <= din;
        end
    end

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(q_valid && q_unavail));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!q_valid && !q_unavail));

endmodule

// File: rtl/sha2_sigma_vec.sv
module sha2_sigma_vec
    import sha2_sigma_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES*WORD_W-1:0]   in_vec,
    input  logic                      in_kind,
    input  logic [LANES-1:0]          in_sel,
    input  logic                      vec_en,
    output logic                      out_valid,
    output logic [LANES*WORD_W-1:0]   out_vec,
    output logic                      out_unavail
);

    localparam int unsigned VEC_W = LANES * WORD_W;

    logic             issue_ok;
    logic             issue_refused;
    logic [VEC_W-1:0] lane_bus;

    assign issue_ok      = in_valid && vec_en;
    assign issue_refused = in_valid && !vec_en;

    // Lane 0 sits in the most significant word
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned HI = VEC_W - 1 - i * WORD_W;
        sig_fn_e lane_fn;
        assign lane_fn = sig_fn_e'({in_kind, in_sel[i]});

        sha2_sigma_lane u_lane (
            .fn   (lane_fn),
            .din  (in_vec[HI -: WORD_W]),
            .dout (lane_bus[HI -: WORD_W])
        );
    end

    sha2_sigma_stage #(.VEC_W(VEC_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .take      (issue_ok),
        .refuse    (issue_refused),
        .din       (lane_bus),
        .q_valid   (out_valid),
        .q_unavail (out_unavail),
        .q_data    (out_vec)
    );

    // R7
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_en) |=> (out_valid && !out_unavail));

    // R8
    refuse_to_unavail_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !vec_en) |=> (out_unavail && !out_valid));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_unavail));

endmodule

// File: tb/tb_sha2_sigma_vec.sv
module tb_sha2_sigma_vec;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_vec;
    logic         in_kind;
    logic [3:0]   in_sel;
    logic         vec_en;
    logic         out_valid;
    logic [127:0] out_vec;
    logic         out_unavail;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sha2_sigma_vec dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .in_kind(in_kind), .in_sel(in_sel), .vec_en(vec_en),
        .out_valid(out_valid), .out_vec(out_vec), .out_unavail(out_unavail)
    );

    function automatic logic [31:0] ror(input logic [31:0] w, input int n);
        logic [63:0] d;
        d = {w, w};
        return d[n +: 32];
    endfunction

    function automatic logic [31:0] ref_word(input bit kind, input bit sel, input logic [31:0] w);
        case ({kind, sel})
            2'b00:   return ror(w, 7)  ^ ror(w, 18) ^ (w >> 3);
            2'b01:   return ror(w, 17) ^ ror(w, 19) ^ (w >> 10);
            2'b10:   return ror(w, 2)  ^ ror(w, 13) ^ ror(w, 22);
            default: return ror(w, 6)  ^ ror(w, 11) ^ ror(w, 25);
        endcase
    endfunction

    function automatic logic [127:0] ref_vec(input bit kind, input logic [3:0] sel, input logic [127:0] v);
        logic [127:0] r;
        for (int i = 0; i < 4; i++)
            r[127-32*i -: 32] = ref_word(kind, sel[i], v[127-32*i -: 32]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_result(input bit kind, input logic [3:0] sel, input logic [127:0] v);
        logic [127:0] e;
        e = ref_vec(kind, sel, v);
        for (int i = 0; i < 4; i++) begin
            string tag;
            case ({kind, sel[i]})
                2'b00:   tag = "R2";
                2'b01:   tag = "R3";
                2'b10:   tag = "R4";
                default: tag = "R5";
            endcase
            chk($sformatf("R1/%s/R6 lane%0d kind=%0d sel=%h", tag, i, kind, sel),
                128'(out_vec[127-32*i -: 32]), 128'(e[127-32*i -: 32]));
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        in_vec   = '0;
        in_kind  = 1'b0;
        in_sel   = '0;
        vec_en   = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b1; vec_en = 1'b1; in_vec = {4{32'hDEADBEEF}};
        repeat (3) @(negedge clk);
        chk("R9 out_valid in reset", 128'(out_valid), 128'(0));
        chk("R9 out_unavail in reset", 128'(out_unavail), 128'(0));
        vec_en = 1'b0;
        @(negedge clk);
        chk("R9 out_unavail in reset, vec_en=0", 128'(out_unavail), 128'(0));
        idle_inputs();
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_op(input bit kind, input logic [3:0] sel, input logic [127:0] v);
        in_valid = 1'b1; vec_en = 1'b1; in_kind = kind; in_sel = sel; in_vec = v;
        @(negedge clk);
        idle_inputs();
        chk("R7 out_valid after issue", 128'(out_valid), 128'(1));
        chk("R8 out_unavail low on enabled issue", 128'(out_unavail), 128'(0));
        chk_result(kind, sel, v);
    endtask

    task automatic t_all_combos();
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0001;
        pats[3] = 32'h8000_0000; pats[4] = 32'hAAAA_AAAA; pats[5] = 32'h5555_5555;
        for (int k = 0; k < 2; k++) begin
            for (int s = 0; s < 16; s++) begin
                for (int p = 0; p < 6; p++) begin
                    logic [127:0] v;
                    v = {pats[p], pats[(p+1)%6], pats[(p+2)%6], pats[(p+3)%6]};
                    run_op(k[0], s[3:0], v);
                end
                run_op(k[0], s[3:0], {$urandom(), $urandom(), $urandom(), $urandom()});
                run_op(k[0], s[3:0], {32'h0000_0400, 32'h0002_0000, 32'h0100_0000, 32'h0000_0008});
            end
        end
    endtask

    task automatic t_unavail();
        in_valid = 1'b1; vec_en = 1'b0; in_kind = 1'b1; in_sel = 4'h5;
        in_vec = {4{32'h1234_5678}};
        @(negedge clk);
        idle_inputs();
        chk("R8 out_unavail pulse", 128'(out_unavail), 128'(1));
        chk("R8 out_valid low when refused", 128'(out_valid), 128'(0));
        @(negedge clk);
        chk("R8 out_unavail drops after one cycle", 128'(out_unavail), 128'(0));
    endtask

    task automatic t_idle();
        for (int n = 0; n < 4; n++) begin
            in_valid = 1'b0; vec_en = n[0]; in_kind = n[1]; in_sel = 4'hF;
            in_vec = {$urandom(), $urandom(), $urandom(), $urandom()};
            @(negedge clk);
            chk("R10 out_valid idle", 128'(out_valid), 128'(0));
            chk("R10 out_unavail idle", 128'(out_unavail), 128'(0));
        end
        idle_inputs();
    endtask

    task automatic t_back_to_back();
        bit           en_q [6];
        bit           kd_q [6];
        logic [3:0]   sl_q [6];
        logic [127:0] v_q  [6];
        for (int n = 0; n < 6; n++) begin
            en_q[n] = (n != 2) && (n != 3);
            kd_q[n] = n[0];
            sl_q[n] = 4'(n * 5);
            v_q[n]  = {$urandom(), $urandom(), $urandom(), $urandom()};
        end
        for (int n = 0; n <= 6; n++) begin
            if (n < 6) begin
                in_valid = 1'b1; vec_en = en_q[n]; in_kind = kd_q[n];
                in_sel = sl_q[n]; in_vec = v_q[n];
            end else begin
                idle_inputs();
            end
            if (n > 0) begin
                chk($sformatf("R7 back-to-back valid op%0d", n-1), 128'(out_valid), 128'(en_q[n-1]));
                chk($sformatf("R8 back-to-back unavail op%0d", n-1), 128'(out_unavail), 128'(!en_q[n-1]));
                if (en_q[n-1]) chk_result(kd_q[n-1], sl_q[n-1], v_q[n-1]);
            end
            @(negedge clk);
        end
        chk("R7 valid drops after stream", 128'(out_valid), 128'(0));
        chk("R8 unavail low after stream", 128'(out_unavail), 128'(0));
    endtask

    task automatic t_reset_mid();
        in_valid = 1'b1; vec_en = 1'b1; in_vec = {4{32'hCAFE_F00D}};
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset overrides issue", 128'(out_valid), 128'(0));
        rst = 1'b0;
        idle_inputs();
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_combos();
        t_unavail();
        t_idle();
        t_back_to_back();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule